// File: doc/BRIEF.md
# Extended Register Unlock Key Matcher

This block watches the CPU's I/O write cycles aimed at one port (the one selected by a fixed value of the upper address byte) and compares each written byte against a fixed 17-byte key. The bytes must arrive as consecutive qualifying writes. When the last key byte is accepted, a sticky `unlocked` level rises. Downstream logic uses that level to make a hidden set of extended registers reachable. Until the whole key has been seen, those registers stay out of reach.

A byte that breaks the key sends the matcher back to its start. If that byte is itself the first key byte, it opens a new attempt. This matters because the key starts FF, 00, FF: the stream FF FF 00 still lines up. The current match position is brought out so a bench can follow progress. The key and the port value are fixed by the package and the top parameters.

Top module: `xreg_key_matcher`

## Requirements
- R1: While `rstN` is low, `unlocked` is 0 and `matchIdx` is 0. Both hold those values in the first cycle after reset is released.
- R2: A qualifying write moves `matchIdx` from i to i+1 at the next rising clock edge when all of these hold: the block is locked, i is below 16, and `wrData` equals key byte i. A qualifying write is one with `ioWrEn`=1 and `addrHi`=`PORT_SEL` (default 8'hBC).
- R3: The key bytes for positions 0 to 16 are, in order: FF, 00, FF, 77, B3, 51, A8, D4, 62, 39, 9C, 46, 2B, 15, 8A, CD, EE (hex).
- R4: A cycle with `ioWrEn`=0, or with `addrHi` different from `PORT_SEL`, leaves both `matchIdx` and `unlocked` unchanged, whatever the value of `wrData`.
- R5: A qualifying write while locked whose byte differs from key byte `matchIdx` sets `matchIdx` to 1 if the byte is FF, and to 0 otherwise.
- R6: A qualifying write of EE while locked at `matchIdx`=16 sets `unlocked` to 1 and `matchIdx` to 0 at the next edge.
- R7: Once set, `unlocked` stays 1 until reset. While unlocked, no write changes `matchIdx` from 0.
- R8: `matchIdx` never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioWrEn | input | 1 | CPU I/O write strobe for this cycle |
| addrHi | input | ADDR_W (8) | Upper byte of the I/O address |
| wrData | input | 8 | Byte written by the CPU |
| unlocked | output | 1 | Sticky unlock level |
| matchIdx | output | 5 | Number of key bytes matched so far |

## Verification
The bench builds the block with its default parameters: an 8-bit upper address, a port select of BC, and the fixed 17-byte key. These defaults make every key position reachable with short write streams. They cover the full unlock and the restart on the FF that overlaps the key's own prefix (FF FF 00 ...). They also cover a miss on the final byte, writes to other ports and non-write cycles mixed in mid-key, and traffic after unlock. A behavioural model in the bench predicts both outputs every cycle.

// File: rtl/xkey_pkg.sv
package xkey_pkg;
  localparam int KEY_LEN = 17;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = $clog2(KEY_LEN);

  typedef struct packed {
    logic incIdx;
    logic loadOne;
    logic clrIdx;
  } idx_strobe_t;

  typedef enum logic {ST_HUNT = 1'b0, ST_OPEN = 1'b1} gate_state_t;

  // Fixed unlock key, position 0 first.
  function automatic logic [DATA_W-1:0] keyByte(input logic [IDX_W-1:0] pos);
    case (pos)
      5'd0:  keyByte = 8'hFF;
      5'd1:  keyByte = 8'h00;
      5'd2:  keyByte = 8'hFF;
      5'd3:  keyByte = 8'h77;
      5'd4:  keyByte = 8'hB3;
      5'd5:  keyByte = 8'h51;
      5'd6:  keyByte = 8'hA8;
      5'd7:  keyByte = 8'hD4;
      5'd8:  keyByte = 8'h62;
      5'd9:  keyByte = 8'h39;
      5'd10: keyByte = 8'h9C;
      5'd11: keyByte = 8'h46;
      5'd12: keyByte = 8'h2B;
      5'd13: keyByte = 8'h15;
      5'd14: keyByte = 8'h8A;
      5'd15: keyByte = 8'hCD;
      5'd16: keyByte = 8'hEE;
      default: keyByte = '0;
    endcase
  endfunction
endpackage

// File: rtl/xkey_datapath.sv
module xkey_datapath
  import xkey_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  idx_strobe_t       strobe,
  output logic              byteHit,
  output logic              firstHit,
  output logic              atLast,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(KEY_LEN - 1);

  logic [IDX_W-1:0] idxNext;

  // Compare against the expected byte and against the key start.
  assign byteHit  = (wrData == keyByte(idx));
  assign firstHit = (wrData == keyByte('0));
  assign atLast   = (idx == LAST_POS);

  always_comb begin
    idxNext = idx;
    if (strobe.clrIdx)       idxNext = '0;
    else if (strobe.loadOne) idxNext = IDX_W'(1);
    else if (strobe.incIdx)  idxNext = idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idx <= '0;
    else       idx <= idxNext;
  end
endmodule

// File: rtl/xkey_control.sv
module xkey_control
  import xkey_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_SEL = 8'hBC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic [ADDR_W-1:0] addrHi,
  input  logic              byteHit,
  input  logic              firstHit,
  input  logic              atLast,
  output idx_strobe_t       strobe,
  output logic              isOpen
);
  gate_state_t state, stateNext;
  logic        portWrite;

  assign portWrite = ioWrEn && (addrHi == PORT_SEL);
  assign isOpen    = (state == ST_OPEN);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (state == ST_HUNT && portWrite) begin
      if (byteHit && atLast) begin
        strobe.clrIdx = 1'b1;
        stateNext     = ST_OPEN;
      end else if (byteHit) begin
        strobe.incIdx = 1'b1;
      end else if (firstHit) begin
        strobe.loadOne = 1'b1;
      end else begin
        strobe.clrIdx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= stateNext;
  end
endmodule

// File: rtl/xreg_key_matcher.sv
module xreg_key_matcher
  import xkey_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_SEL = 8'hBC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic [ADDR_W-1:0] addrHi,
  input  logic [DATA_W-1:0] wrData,
  output logic              unlocked,
  output logic [IDX_W-1:0]  matchIdx
);
  idx_strobe_t strobe;
  logic        byteHit, firstHit, atLast;

  xkey_control #(.ADDR_W(ADDR_W), .PORT_SEL(PORT_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .addrHi(addrHi),
    .byteHit(byteHit), .firstHit(firstHit), .atLast(atLast),
    .strobe(strobe), .isOpen(unlocked)
  );

  xkey_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe),
    .byteHit(byteHit), .firstHit(firstHit), .atLast(atLast), .idx(matchIdx)
  );
endmodule

// File: rtl/xreg_key_matcher_chk.sv
module xreg_key_matcher_chk
  import xkey_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_SEL = 8'hBC
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioWrEn,
  input logic [ADDR_W-1:0] addrHi,
  input logic [DATA_W-1:0] wrData,
  input logic              unlocked,
  input logic [IDX_W-1:0]  matchIdx
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(KEY_LEN - 1);
  logic qual;
  assign qual = ioWrEn && (addrHi == PORT_SEL);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!unlocked && matchIdx == '0));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rstN)
    (qual && !unlocked && matchIdx != LAST_POS && wrData == keyByte(matchIdx))
    |=> matchIdx == $past(matchIdx) + IDX_W'(1));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !qual |=> ($stable(matchIdx) && $stable(unlocked)));

  a_r5_restart: assert property (@(posedge clk) disable iff (!rstN)
    (qual && !unlocked && wrData != keyByte(matchIdx))
    |=> matchIdx == ((($past(wrData)) == 8'hFF) ? IDX_W'(1) : IDX_W'(0)));

  a_r6_open: assert property (@(posedge clk) disable iff (!rstN)
    (qual && !unlocked && matchIdx == LAST_POS && wrData == 8'hEE)
    |=> (unlocked && matchIdx == '0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |=> (unlocked && matchIdx == '0));

  a_r8_bound: assert property (@(posedge clk) disable iff (!rstN)
    matchIdx <= LAST_POS);
endmodule

bind xreg_key_matcher xreg_key_matcher_chk #(.ADDR_W(ADDR_W), .PORT_SEL(PORT_SEL)) u_chk (
  .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .addrHi(addrHi), .wrData(wrData),
  .unlocked(unlocked), .matchIdx(matchIdx)
);

// File: tb/test_xreg_key_matcher.sv
module test_xreg_key_matcher;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ioWrEn = 1'b0;
  logic [7:0] addrHi = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic       unlocked;
  logic [4:0] matchIdx;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int key[17] = '{8'hFF, 8'h00, 8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4,
                  8'h62, 8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hEE};
  int  mIdx = 0;
  bit  mOpen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xreg_key_matcher i_xreg_key_matcher (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .addrHi(addrHi), .wrData(wrData),
    .unlocked(unlocked), .matchIdx(matchIdx)
  );

  task automatic compare(input string tag);
    checks++;
    if (unlocked !== mOpen || int'(matchIdx) != mIdx) begin
      errors++;
      $display("FAIL %s: unlocked=%0b idx=%0d expected unlocked=%0b idx=%0d",
               tag, unlocked, matchIdx, mOpen, mIdx);
    end
  endtask

  // Drive one cycle at the falling edge, update the model at the rising
  // edge, compare at the next falling edge.
  task automatic cyc(input bit wr, input int hi, input int d, input string tag);
    ioWrEn = wr; addrHi = 8'(hi); wrData = 8'(d);
    @(posedge clk);
    if (wr && hi == 8'hBC && !mOpen) begin
      if (d == key[mIdx]) begin
        if (mIdx == 16) begin mOpen = 1; mIdx = 0; end
        else mIdx++;
      end else mIdx = (d == 8'hFF) ? 1 : 0;
    end
    @(negedge clk);
    ioWrEn = 0;
    compare(tag);
  endtask

  task automatic doReset();
    rstN = 0; mIdx = 0; mOpen = 0;
    @(negedge clk);
    compare("R1 during reset");
    rstN = 1;
    @(negedge clk);
    compare("R1 after release");
  endtask

  task automatic sendKey(input int upto, input string tag);
    for (int k = 0; k < upto; k++) cyc(1, 8'hBC, key[k], tag);
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // Partial key with foreign ports and idle cycles interleaved.
    sendKey(5, "R2 R3 partial key");
    cyc(1, 8'h7F, 8'h00, "R4 other port");
    cyc(0, 8'hBC, 8'h12, "R4 no write strobe");
    cyc(1, 8'hBD, key[5], "R4 neighbour port");
    // Miss with non-FF byte.
    cyc(1, 8'hBC, 8'h42, "R5 miss to zero");
    // Overlapping prefix: FF FF 00 FF ...
    cyc(1, 8'hBC, 8'hFF, "R5 first byte");
    cyc(1, 8'hBC, 8'hFF, "R5 FF restart to one");
    for (int k = 1; k < 16; k++) cyc(1, 8'hBC, key[k], "R2 R3 continue after restart");
    cyc(1, 8'hBC, 8'h00, "R5 miss on last byte");
    for (int k = 0; k < 16; k++) cyc(1, 8'hBC, key[k], "R8 run to last position");
    cyc(1, 8'hBC, 8'hFF, "R5 FF at last position");
    doReset();
    sendKey(17, "R6 full key unlocks");
    for (int k = 0; k < 20; k++) cyc(1, 8'hBC, key[k % 17], "R7 writes after unlock");
    cyc(1, 8'h10, 8'h42, "R7 foreign write after unlock");
    for (int k = 0; k < 5; k++) cyc(0, 8'h00, 8'h00, "R7 idle after unlock");
    doReset();
    sendKey(17, "R6 second unlock");
    done = 1;
  end

  initial begin
    for (int t = 0; t < 5000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule